// File: doc/BRIEF.md
# Audio Sample Record and Playback Sequencer

This block moves a block of audio samples between a converter pair and a local single-port RAM of 4096 words by 16 bits. On a record request it walks the whole RAM from word 0 to word 4095. For each word it strobes the analog-to-digital converter to take a sample, then writes that 12-bit sample into the low bits of the word. On a play request it walks the same range, reading each word and, one cycle later, strobing the digital-to-analog converter with the low 12 bits of the returned word.

A single 12-bit address register serves both sweeps. An outer controller issues record and play requests and watches the busy and done outputs. The RAM is a synchronous part with one cycle of read latency. A behavioural model of it is part of the project for the testbench.

Top module: `sndbuf_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after reset, busy, done, adc_load, dac_load and ram_en are low and ram_addr is 0.
- R2: Each record step takes two cycles. In the first, adc_load is high for one cycle. In the second, ram_en=1 and ram_rw=1 at the current address, with ram_wdata equal to adc_sample in bits 11:0 and zeros in bits 15:12.
- R3: Each play step reads with ram_en=1 and ram_rw=0 at the current address, and adc_load stays low for the whole playback sweep.
- R4: dac_load is high exactly in the cycle after each RAM read, and dac_data then equals bits 11:0 of ram_rdata.
- R5: The address starts at 0 and increases by one after each write or read. A sweep makes exactly 4096 accesses, at addresses 0 through 4095 in order.
- R6: A record or play request that arrives while a sweep is running is ignored, and the sweep's access count and direction are unchanged.
- R7: If record and play are requested in the same idle cycle, recording starts.
- R8: A playback that follows a recording presents on dac_data the recorded samples in recording order, for all 4096 addresses.
- R9: busy is high from the cycle after an accepted request until the last access. done is then high for one cycle with busy low, after which the block is idle with address 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rec_start | input | 1 | Record request, sampled when idle |
| play_start | input | 1 | Play request, sampled when idle |
| busy | output | 1 | A sweep is running |
| done | output | 1 | One-cycle pulse after the final access |
| adc_load | output | 1 | Converter sample strobe |
| adc_sample | input | 12 | Converter sample, valid the cycle after adc_load |
| dac_load | output | 1 | Output converter load strobe |
| dac_data | output | 12 | Sample for the output converter |
| ram_addr | output | 12 | RAM word address |
| ram_en | output | 1 | RAM access enable |
| ram_rw | output | 1 | 1 = write, 0 = read |
| ram_wdata | output | 16 | RAM write word |
| ram_rdata | input | 16 | RAM read word, valid one cycle after a read |

## Verification
The assertions take for granted that the RAM returns a read word on the clock edge after the read cycle. They also assume the converter sample is stable for the whole write cycle that follows adc_load. The bench keeps to these conditions. Its RAM model registers its output on the read edge, its converter model changes the sample only on the edge that ends a load strobe, and all requests are driven away from the active edge as single-cycle pulses.

// File: rtl/sndbuf_pkg.sv
// Shared types for the sample record/playback sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package sndbuf_pkg;

    typedef enum logic [2:0] {
        ST_IDLE       = 3'd0,
        ST_REC_SAMPLE = 3'd1,
        ST_REC_WRITE  = 3'd2,
        ST_PLAY_READ  = 3'd3,
        ST_PLAY_LOAD  = 3'd4,
        ST_DONE       = 3'd5
    } sweep_state_e;

endpackage

// File: rtl/sndbuf_addr.sv
// Sweep address register: clears on reset and steps by one on inc,
// wrapping to zero after the top word. at_last flags the top word.
// Assumes: inc is only raised by the sequencer on a completed access.
module sndbuf_addr #(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc,
    output logic [ADDR_W-1:0] addr,
    output logic              at_last
);

    localparam logic [ADDR_W-1:0] LAST_ADDR = {ADDR_W{1'b1}};

    // Address register: hold, or advance after each access.
    always_ff @(posedge clk) begin
        if (!rst_n)
            addr <= '0;
        else if (inc)
            addr <= addr + 1'b1;
    end

    // Top-word flag that ends the sweep.
    assign at_last = (addr == LAST_ADDR);

    // R5: each access advances the address by exactly one.
    p_addr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        inc |=> (addr == $past(addr) + 1'b1));

    // R5: without an access the address holds.
    p_addr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !inc |=> $stable(addr));

endmodule

// File: rtl/sndbuf_fsm.sv
// Sweep sequencer: accepts a record or play request when idle (record
// first), then runs two-cycle steps until the top address is handled.
// Assumes: at_last reflects the address used by the current step.
module sndbuf_fsm
    import sndbuf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rec_req,
    input  logic play_req,
    input  logic at_last,
    output logic adc_load,
    output logic ram_en,
    output logic ram_rw,
    output logic dac_load,
    output logic busy,
    output logic done,
    output logic inc
);

    sweep_state_e state, state_nx;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    // Next-state choice; requests are only looked at when idle.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (rec_req)
                    state_nx = ST_REC_SAMPLE;
                else if (play_req)
                    state_nx = ST_PLAY_READ;
            end
            ST_REC_SAMPLE: state_nx = ST_REC_WRITE;
            ST_REC_WRITE:  state_nx = at_last ? ST_DONE : ST_REC_SAMPLE;
            ST_PLAY_READ:  state_nx = ST_PLAY_LOAD;
            ST_PLAY_LOAD:  state_nx = at_last ? ST_DONE : ST_PLAY_READ;
            ST_DONE:       state_nx = ST_IDLE;
            default:       state_nx = ST_IDLE;
        endcase
    end

    // Strobe decode from the registered state (stable across each edge).
    always_comb begin
        adc_load = (state == ST_REC_SAMPLE);
        ram_en   = (state == ST_REC_WRITE) || (state == ST_PLAY_READ);
        ram_rw   = (state == ST_REC_WRITE);
        dac_load = (state == ST_PLAY_LOAD);
        done     = (state == ST_DONE);
        busy     = (state != ST_IDLE) && (state != ST_DONE);
        inc      = (state == ST_REC_WRITE) || (state == ST_PLAY_LOAD);
    end

    // R2: a sample strobe is always followed by the RAM write.
    p_write_after_sample_r2: assert property (@(posedge clk) disable iff (!rst_n)
        adc_load |=> (ram_en && ram_rw));

    // R3: the converter is never strobed during a read.
    p_no_adc_on_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_en && !ram_rw) |-> !adc_load);

    // R9: done is a single cycle and the block is then idle.
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // R6: a running sweep only ends through done.
    p_busy_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (busy || done));

    // R7: a double request from idle starts a recording.
    p_rec_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !done && rec_req && play_req) |=> adc_load);

endmodule

// File: rtl/sndbuf_ram.sv
// Behavioural synchronous single-port RAM used around the sequencer.
// Writes when en and rw are high; on a read, the word appears after
// the clock edge (one cycle of latency).
// Assumes: no reset of contents is needed.
module sndbuf_ram #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              en,
    input  logic              rw,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Single access port: write or registered read.
    always_ff @(posedge clk) begin
        if (en && rw)
            mem[addr] <= wdata;
        else if (en)
            rdata <= mem[addr];
    end

endmodule

// File: rtl/sndbuf_ctrl.sv
// Record/playback sequencer top: address register plus sweep FSM.
// Samples go into the low bits of each RAM word with zero padding;
// the output converter receives the low bits of the read word.
// Assumes: RAM read data is valid one cycle after the read cycle.
module sndbuf_ctrl #(
    parameter int ADDR_W   = 12,
    parameter int DATA_W   = 16,
    parameter int SAMPLE_W = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rec_start,
    input  logic                play_start,
    output logic                busy,
    output logic                done,
    output logic                adc_load,
    input  logic [SAMPLE_W-1:0] adc_sample,
    output logic                dac_load,
    output logic [SAMPLE_W-1:0] dac_data,
    output logic [ADDR_W-1:0]   ram_addr,
    output logic                ram_en,
    output logic                ram_rw,
    output logic [DATA_W-1:0]   ram_wdata,
    input  logic [DATA_W-1:0]   ram_rdata
);

    localparam int PAD_W = DATA_W - SAMPLE_W;

    logic step_inc;
    logic addr_last;
    logic unused_rdata_hi;

    sndbuf_addr #(.ADDR_W(ADDR_W)) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc     (step_inc),
        .addr    (ram_addr),
        .at_last (addr_last)
    );

    sndbuf_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .rec_req  (rec_start),
        .play_req (play_start),
        .at_last  (addr_last),
        .adc_load (adc_load),
        .ram_en   (ram_en),
        .ram_rw   (ram_rw),
        .dac_load (dac_load),
        .busy     (busy),
        .done     (done),
        .inc      (step_inc)
    );

    // Zero-extend the sample into the RAM word.
    generate
        if (PAD_W > 0) begin : g_pad
            assign ram_wdata = {{PAD_W{1'b0}}, adc_sample};
            assign unused_rdata_hi = ^ram_rdata[DATA_W-1:SAMPLE_W];
        end else begin : g_nopad
            assign ram_wdata = adc_sample[DATA_W-1:0];
            assign unused_rdata_hi = 1'b0;
        end
    endgenerate

    // Output converter word: low bits of the returned RAM word.
    assign dac_data = ram_rdata[SAMPLE_W-1:0];

    // R4: every read is followed by a converter load in the next cycle.
    p_dac_after_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_en && !ram_rw) |=> dac_load);

    // R4: a converter load only ever follows a read.
    p_dac_needs_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dac_load |-> $past(ram_en && !ram_rw));

    // R5: the sweep finishes on the top address and restarts at zero.
    p_done_at_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (ram_addr == '0));

endmodule

// File: tb/test_sndbuf_ctrl.sv
module test_sndbuf_ctrl;

    localparam int AW = 12;
    localparam int DW = 16;
    localparam int SW = 12;
    localparam int WORDS = 1 << AW;

    // Sweep patterns: {seed, step}; sample i = seed + step*i (mod 4096).
    localparam logic [23:0] PATS [4] = '{
        {12'h000, 12'h001},
        {12'hA5A, 12'h007},
        {12'hFFF, 12'hFFF},
        {12'h800, 12'h000}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rec_start = 1'b0;
    logic play_start = 1'b0;
    logic busy, done, adc_load, dac_load, ram_en, ram_rw;
    logic [SW-1:0] adc_sample = '0;
    logic [SW-1:0] dac_data;
    logic [AW-1:0] ram_addr;
    logic [DW-1:0] ram_wdata, ram_rdata;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    // Pattern state set by the main flow, read by the models.
    logic [11:0] cur_seed = '0;
    logic [11:0] cur_step = '0;
    int wr_base = 0, rd_base = 0, dac_base = 0, adc_base = 0;

    // Counters written only by the models/monitor.
    int adc_cnt = 0, wr_cnt = 0, rd_cnt = 0, dac_cnt = 0;
    int wr_bad = 0, rd_bad = 0, dac_bad = 0, dac_late = 0;
    logic prev_read = 1'b0;

    always #2.5 clk = ~clk;

    sndbuf_ctrl i_sndbuf_ctrl (
        .clk(clk), .rst_n(rst_n), .rec_start(rec_start), .play_start(play_start),
        .busy(busy), .done(done), .adc_load(adc_load), .adc_sample(adc_sample),
        .dac_load(dac_load), .dac_data(dac_data), .ram_addr(ram_addr),
        .ram_en(ram_en), .ram_rw(ram_rw), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
    );

    sndbuf_ram #(.ADDR_W(AW), .DATA_W(DW)) i_ram (
        .clk(clk), .en(ram_en), .rw(ram_rw), .addr(ram_addr),
        .wdata(ram_wdata), .rdata(ram_rdata)
    );

    function automatic logic [11:0] pat(input logic [11:0] s, input logic [11:0] st, input int i);
        logic [11:0] ii;
        ii = i[11:0];
        return s + st * ii;
    endfunction

    // Converter model: a new sample appears on the edge ending a strobe.
    always @(posedge clk) begin
        if (rst_n && adc_load) begin
            adc_sample <= pat(cur_seed, cur_step, adc_cnt - adc_base);
            adc_cnt <= adc_cnt + 1;
        end
    end

    // Monitor away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (ram_en && ram_rw) begin
                if (ram_addr != AW'(wr_cnt - wr_base)) wr_bad <= wr_bad + 1;
                if (ram_wdata != {4'h0, pat(cur_seed, cur_step, wr_cnt - wr_base)})
                    wr_bad <= wr_bad + 1;
                wr_cnt <= wr_cnt + 1;
            end
            if (ram_en && !ram_rw) begin
                if (ram_addr != AW'(rd_cnt - rd_base) || adc_load) rd_bad <= rd_bad + 1;
                rd_cnt <= rd_cnt + 1;
            end
            if (dac_load) begin
                if (dac_data != pat(cur_seed, cur_step, dac_cnt - dac_base))
                    dac_bad <= dac_bad + 1;
                if (!prev_read) dac_late <= dac_late + 1;
                dac_cnt <= dac_cnt + 1;
            end else if (prev_read) begin
                dac_late <= dac_late + 1;
            end
            prev_read <= ram_en && !ram_rw;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic snap();
        wr_base = wr_cnt; rd_base = rd_cnt; dac_base = dac_cnt; adc_base = adc_cnt;
    endtask

    task automatic pulse(input logic r, input logic p);
        @(negedge clk);
        rec_start = r; play_start = p;
        @(negedge clk);
        rec_start = 1'b0; play_start = 1'b0;
    endtask

    task automatic wait_done();
        while (!done) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        // R1: reset state, during and just after reset.
        repeat (3) @(negedge clk);
        check(!busy && !done && !adc_load && !dac_load && !ram_en && ram_addr == 0,
              "R1 in reset", {busy, done, adc_load, dac_load, ram_en}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !adc_load && !dac_load && !ram_en && ram_addr == 0,
              "R1 after reset", int'(ram_addr), 0);

        // Table walk: record then play each pattern.
        for (int k = 0; k < 4; k++) begin
            cur_seed = PATS[k][23:12];
            cur_step = PATS[k][11:0];
            snap();
            pulse(1'b1, 1'b0);
            check(busy, "R9 busy after record request", busy, 1);
            wait_done();
            check(!busy, "R9 busy low at done", busy, 0);
            check(wr_bad == 0, "R2 write address/data", wr_bad, 0);
            check(wr_cnt - wr_base == WORDS, "R5 write count", wr_cnt - wr_base, WORDS);
            @(negedge clk);
            check(!done && ram_addr == 0, "R9 done one cycle, address 0", int'(ram_addr), 0);

            snap();
            pulse(1'b0, 1'b1);
            wait_done();
            check(rd_bad == 0, "R3 read address, no ADC strobe", rd_bad, 0);
            check(rd_cnt - rd_base == WORDS, "R5 read count", rd_cnt - rd_base, WORDS);
            check(adc_cnt == adc_base, "R3 no ADC load in play", adc_cnt - adc_base, 0);
            check(dac_late == 0, "R4 DAC load one cycle after read", dac_late, 0);
            check(dac_bad == 0 && dac_cnt - dac_base == WORDS,
                  "R8 playback order", dac_bad, 0);
            @(negedge clk);
        end

        // R7: both requests together start a recording.
        cur_seed = 12'h123;
        cur_step = 12'h011;
        snap();
        pulse(1'b1, 1'b1);
        check(adc_load && busy, "R7 record wins", adc_load, 1);

        // R6: requests during the sweep are ignored.
        repeat (50) @(negedge clk);
        play_start = 1'b1;
        @(negedge clk);
        play_start = 1'b0;
        repeat (20) @(negedge clk);
        rec_start = 1'b1;
        @(negedge clk);
        rec_start = 1'b0;
        wait_done();
        check(wr_cnt - wr_base == WORDS && rd_cnt == rd_base,
              "R6 sweep unchanged by requests", wr_cnt - wr_base, WORDS);
        check(wr_bad == 0, "R6 write sequence intact", wr_bad, 0);
        @(negedge clk);
        check(!busy && !done && ram_addr == 0, "R9 idle after sweep", busy, 0);

        // R8: playback of that recording.
        snap();
        pulse(1'b0, 1'b1);
        wait_done();
        check(dac_bad == 0 && dac_cnt - dac_base == WORDS, "R8 replay after R6 sweep",
              dac_cnt - dac_base, WORDS);

        // R1: reset in the middle of a sweep returns to the idle state.
        pulse(1'b1, 1'b0);
        repeat (10) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !adc_load && !ram_en && ram_addr == 0, "R1 mid-sweep reset",
              int'(ram_addr), 0);

        finish_run();
    end

endmodule